// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Sequencer

This block sits between a clocked request source and an external 16-bit static RAM that has no clock of its own. Each accepted request becomes one read cycle or one write cycle on the RAM pins. The RAM pins are chip select, output enable, write strobe and one enable per byte lane, all active low. The nanosecond minimums the RAM needs are module parameters. At elaboration each one becomes a clock count: the time is divided by the clock period, rounded up, and one cycle is added as margin for output skew.

A request is offered with a valid/ready handshake. It carries a write flag, an address, a data word and a byte-lane mask. Only one request is in flight at a time. A read returns its data together with a one-cycle done pulse. A write also ends with a done pulse. The data bus is split into an output word, an output-enable and an input word, so that the pad ring can build the tri-state buffer. After every read the controller waits a release interval before it can drive the bus again.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held, chip select, output enable, write strobe and both byte enables are high (inactive), the data bus is not driven, reqDone is low and reqReady is high.
- R2: A request is taken on a clock edge where reqValid and reqReady are both high. reqReady then stays low until the cycle has finished. Inputs that change while reqReady is low are ignored.
- R3: A read holds chip select, output enable and the byte enables (sramBeN = ~mask) low for RD_CYC consecutive cycles, with the address constant. RD_CYC is the largest of the converted read-cycle, address-access and output-enable-access times, which is 4 at a 20 ns clock. These pins go low two cycles after the accepting edge.
- R4: Read data is sampled at the edge where chip select and output enable return high. It appears on rdData in the next cycle, together with a one-cycle reqDone. Mask bit i selects data bits [8i+7:8i] and byte enable bit i. A byte whose mask bit is 0 reads as zero.
- R5: The controller does not drive the data bus again until at least REC_CYC cycles after output enable has gone high. REC_CYC is the converted release time, which is 2 at 20 ns.
- R6: A write holds the write strobe low for WR_CYC cycles, which is 3 at 20 ns. For that whole time chip select and the selected byte enables are low, and the request's data is driven and stable.
- R7: After the write strobe rises there is one hold cycle. In that cycle chip select stays low, the address and data are unchanged and still driven, and reqDone pulses. The bus and chip select are released in the following cycle.
- R8: In a write, chip select is low for at least the converted full write-cycle time. That time is 4 cycles at 20 ns.
- R9: The byte enables change only on the edge where chip select falls. They hold their value in every cycle in which chip select stays high.
- R10: Output enable and the write strobe are never low at the same time, and the bus is never driven while output enable is low.
- R11: Every accepted request produces exactly one reqDone pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqMask | input | DATA_W/8 | Byte-lane select, bit i = bits [8i+7:8i] |
| rdData | output | DATA_W | Captured read data, masked lanes zero |
| reqDone | output | 1 | One-cycle completion pulse |
| sramAddr | output | ADDR_W | RAM address |
| sramCeN | output | 1 | RAM chip select, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramWeN | output | 1 | RAM write strobe, active low |
| sramBeN | output | DATA_W/8 | RAM byte enables, active low |
| sramDqOut | output | DATA_W | Data driven toward the RAM |
| sramDqOe | output | 1 | Drive enable for sramDqOut |
| sramDqIn | input | DATA_W | Data returned from the RAM |

## Verification
The bench builds the controller with a 20 ns clock, an 18-bit address and the default nanosecond minimums. With those values the read window is 4 cycles, the write strobe 3 cycles and the release interval 2 cycles. These small counts keep every boundary within reach: data sampled one cycle early, a write-then-read or read-then-write turnaround, and a byte enable that moves while chip select is high. The bench's RAM model returns a garbage word until output enable has been low for three full cycles, so a shortened read window gives wrong data. Requests are also issued back to back with reqValid held high and the fields changing while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REC,
    ST_WR_PULSE,
    ST_WR_HOLD
  } sramState_t;

  // Strobes from the sequencer to the pin registers
  typedef struct packed {
    logic load;     // latch the request fields
    logic ceAct;    // chip select wanted next cycle
    logic oeAct;    // output enable wanted next cycle
    logic weAct;    // write strobe wanted next cycle
    logic dqDrive;  // data bus driven next cycle
    logic capture;  // sample the returned data at this edge
    logic done;     // write completion
  } sramStrobes_t;

  // Round a nanosecond minimum up to clock cycles, plus one cycle of skew margin
  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned periodNs);
    return (ns + periodNs - 1) / periodNs + 1;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 4,
  parameter int unsigned REC_CYC = 2,
  parameter int unsigned WR_CYC  = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  output logic         reqReady,
  output sramStrobes_t strobes
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOAD  = CNT_W'(WR_CYC - 1);

  sramState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobes   = '0;
    reqReady  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobes.load = 1'b1;
          if (reqWrite) begin
            stateNext = ST_WR_PULSE;
            cntNext   = WR_LOAD;
          end else begin
            stateNext = ST_RD_ACC;
            cntNext   = RD_LOAD;
          end
        end
      end
      ST_RD_ACC: begin
        strobes.ceAct = 1'b1;
        strobes.oeAct = 1'b1;
        if (cnt == '0) begin
          stateNext = ST_RD_REC;
          cntNext   = REC_LOAD;
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_RD_REC: begin
        // first release cycle: pins are still low until this edge
        strobes.capture = (cnt == REC_LOAD);
        if (cnt == '0) stateNext = ST_IDLE;
        else cntNext = cnt - 1'b1;
      end
      ST_WR_PULSE: begin
        strobes.ceAct   = 1'b1;
        strobes.weAct   = 1'b1;
        strobes.dqDrive = 1'b1;
        if (cnt == '0) stateNext = ST_WR_HOLD;
        else cntNext = cnt - 1'b1;
      end
      ST_WR_HOLD: begin
        strobes.ceAct   = 1'b1;
        strobes.dqDrive = 1'b1;
        strobes.done    = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

  AST_CAPTURE_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |-> $past(strobes.oeAct)); // R4

  AST_DRIVE_NOT_WITH_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobes.dqDrive |-> !strobes.oeAct); // R10

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 18,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MASK_W  = DATA_W / 8,
  parameter int unsigned RD_CYC  = 4,
  parameter int unsigned REC_CYC = 2,
  parameter int unsigned WR_CYC  = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [MASK_W-1:0] reqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              reqDone,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [MASK_W-1:0] sramBeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [MASK_W-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sramAddr  <= '0;
      sramDqOut <= '0;
      maskQ     <= '0;
      sramCeN   <= 1'b1;
      sramOeN   <= 1'b1;
      sramWeN   <= 1'b1;
      sramBeN   <= '1;
      sramDqOe  <= 1'b0;
      reqDone   <= 1'b0;
    end else begin
      if (strobes.load) begin
        sramAddr  <= reqAddr;
        sramDqOut <= reqWdata;
        maskQ     <= reqMask;
      end
      sramCeN  <= !strobes.ceAct;
      sramOeN  <= !strobes.oeAct;
      sramWeN  <= !strobes.weAct;
      sramDqOe <= strobes.dqDrive;
      // lanes only move together with an active chip select
      if (strobes.ceAct) sramBeN <= ~maskQ;
      reqDone <= strobes.done | strobes.capture;
    end
  end

  for (genvar lane = 0; lane < MASK_W; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdData[lane*8 +: 8] <= '0;
      end else if (strobes.capture) begin
        rdData[lane*8 +: 8] <= maskQ[lane] ? sramDqIn[lane*8 +: 8] : 8'h00;
      end
    end
  end

  // Pin-level window counters for the timing checks
  logic [CNT_W-1:0] oeLowCnt, weLowCnt, relCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oeLowCnt <= '0;
      weLowCnt <= '0;
      relCnt   <= CNT_MAX;
    end else begin
      if (sramOeN) oeLowCnt <= '0;
      else if (oeLowCnt != CNT_MAX) oeLowCnt <= oeLowCnt + 1'b1;
      if (sramWeN) weLowCnt <= '0;
      else if (weLowCnt != CNT_MAX) weLowCnt <= weLowCnt + 1'b1;
      if (!sramOeN) relCnt <= '0;
      else if (relCnt != CNT_MAX) relCnt <= relCnt + 1'b1;
    end
  end

  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramOeN) |-> (oeLowCnt >= CNT_W'(RD_CYC))); // R3

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramDqOe) |-> (relCnt >= CNT_W'(REC_CYC))); // R5

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (weLowCnt >= CNT_W'(WR_CYC))); // R6

  AST_WE_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> (!sramCeN && sramDqOe)); // R7

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCeN && $past(!sramCeN)) |-> $stable(sramAddr)); // R3

  AST_BE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (sramCeN && $past(sramCeN)) |-> $stable(sramBeN)); // R9

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!sramOeN && !sramWeN)); // R10

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> sramOeN); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone); // R11

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 20,
  parameter int unsigned ADDR_W          = 18,
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned RD_CYCLE_NS     = 45,
  parameter int unsigned ADDR_ACCESS_NS  = 45,
  parameter int unsigned OE_ACCESS_NS    = 22,
  parameter int unsigned RELEASE_NS      = 18,
  parameter int unsigned WR_CYCLE_NS     = 45,
  parameter int unsigned WE_WIDTH_NS     = 35,
  parameter int unsigned DATA_SETUP_NS   = 25,
  parameter int unsigned ADDR_SETUP_NS   = 35,
  parameter int unsigned ENABLE_SETUP_NS = 35
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqMask,
  output logic [DATA_W-1:0]     rdData,
  output logic                  reqDone,
  output logic [ADDR_W-1:0]     sramAddr,
  output logic                  sramCeN,
  output logic                  sramOeN,
  output logic                  sramWeN,
  output logic [DATA_W/8-1:0]   sramBeN,
  output logic [DATA_W-1:0]     sramDqOut,
  output logic                  sramDqOe,
  input  logic [DATA_W-1:0]     sramDqIn
);

  localparam int unsigned MASK_W = DATA_W / 8;

  localparam int unsigned RD_CYC = maxOf(nsToCycles(RD_CYCLE_NS, CLK_PERIOD_NS),
                                   maxOf(nsToCycles(ADDR_ACCESS_NS, CLK_PERIOD_NS),
                                         nsToCycles(OE_ACCESS_NS, CLK_PERIOD_NS)));
  // The hold cycle after the strobe counts toward the full write cycle
  localparam int unsigned WR_CYC = maxOf(maxOf(nsToCycles(WE_WIDTH_NS, CLK_PERIOD_NS),
                                               nsToCycles(DATA_SETUP_NS, CLK_PERIOD_NS)),
                                   maxOf(maxOf(nsToCycles(ADDR_SETUP_NS, CLK_PERIOD_NS),
                                               nsToCycles(ENABLE_SETUP_NS, CLK_PERIOD_NS)),
                                         nsToCycles(WR_CYCLE_NS, CLK_PERIOD_NS) - 1));
  localparam int unsigned REC_CYC = nsToCycles(RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W   = $clog2(maxOf(RD_CYC, maxOf(WR_CYC, REC_CYC)) + 1) + 1;

  sramStrobes_t strobes;

  sram_ctrl_fsm #(
    .RD_CYC (RD_CYC),
    .REC_CYC(REC_CYC),
    .WR_CYC (WR_CYC),
    .CNT_W  (CNT_W)
  ) uFsm (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  sram_ctrl_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .MASK_W (MASK_W),
    .RD_CYC (RD_CYC),
    .REC_CYC(REC_CYC),
    .WR_CYC (WR_CYC),
    .CNT_W  (CNT_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .rdData   (rdData),
    .reqDone  (reqDone),
    .sramAddr (sramAddr),
    .sramCeN  (sramCeN),
    .sramOeN  (sramOeN),
    .sramWeN  (sramWeN),
    .sramBeN  (sramBeN),
    .sramDqOut(sramDqOut),
    .sramDqOe (sramDqOe),
    .sramDqIn (sramDqIn)
  );

endmodule

// File: tb/async_sram_ctrl_test.sv
`timescale 1ns/1ps
module async_sram_ctrl_test;

  localparam int PER = 20;
  function automatic int cyc(input int ns);
    return (ns + PER - 1) / PER + 1;
  endfunction
  localparam int RD_A = cyc(45) > cyc(22) ? cyc(45) : cyc(22);
  localparam int RDN  = RD_A;
  localparam int WR_A = cyc(35) > cyc(25) ? cyc(35) : cyc(25);
  localparam int WRN  = WR_A > (cyc(45) - 1) ? WR_A : (cyc(45) - 1);
  localparam int RECN = cyc(18);
  localparam int WCYC = cyc(45);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, reqDone, sramCeN, sramOeN, sramWeN, sramDqOe;
  logic [15:0] rdData, sramDqOut, sramDqIn;
  logic [17:0] sramAddr;
  logic [1:0]  sramBeN;

  always #10 clk = ~clk;

  async_sram_ctrl #(.CLK_PERIOD_NS(PER), .ADDR_W(18), .DATA_W(16)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rdData(rdData), .reqDone(reqDone), .sramAddr(sramAddr), .sramCeN(sramCeN),
    .sramOeN(sramOeN), .sramWeN(sramWeN), .sramBeN(sramBeN), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- RAM model ----------------
  logic [15:0] mem [256];
  int activeCnt = 0;
  assign sramDqIn = (!sramCeN && !sramOeN && activeCnt >= RDN - 1) ? mem[sramAddr[7:0]] : 16'hDEAD;

  always @(posedge clk) begin
    if (!sramCeN && !sramOeN) activeCnt <= activeCnt + 1;
    else activeCnt <= 0;
    if (!sramCeN && !sramWeN && sramDqOe) begin
      if (!sramBeN[0]) mem[sramAddr[7:0]][7:0]  <= sramDqOut[7:0];
      if (!sramBeN[1]) mem[sramAddr[7:0]][15:8] <= sramDqOut[15:8];
    end
  end

  // ---------------- reference model ----------------
  logic [15:0] shadow [256];
  int mT = 1000, mEnd = 0, accepted = 0, doneSeen = 0;
  bit mIsWr = 0;
  logic [17:0] mAddr = '0;
  logic [15:0] mData = '0, mExpRd = '0;
  logic [1:0]  mMask = '0, mBe = 2'b11;

  function automatic logic [15:0] laneMask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mT = 1000; mEnd = 0; mBe = 2'b11;
    end else begin
      if (mT >= mEnd && reqValid) begin
        mIsWr = reqWrite; mAddr = reqAddr; mData = reqWdata; mMask = reqMask;
        mT = 1;
        accepted++;
        if (reqWrite) begin
          mEnd = WRN + 2;
          shadow[reqAddr[7:0]] = (shadow[reqAddr[7:0]] & ~laneMask(reqMask)) | (reqWdata & laneMask(reqMask));
        end else begin
          mEnd = RDN + RECN + 1;
          mExpRd = shadow[reqAddr[7:0]] & laneMask(reqMask);
        end
      end else if (mT < 100000) begin
        mT++;
      end
      if (mT == 2) mBe = ~mMask;
    end
  end

  int ceRun = 0, relRun = 100;
  bit prevDqOe = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      chk(sramCeN && sramOeN && sramWeN && sramBeN == 2'b11, "R1", "pins idle in reset",
          {sramCeN, sramOeN, sramWeN, sramBeN}, 5'b11111);
      chk(!sramDqOe && !reqDone && reqReady, "R1", "handshake idle in reset",
          {sramDqOe, reqDone, reqReady}, 3'b001);
    end else if (!finished) begin
      bit rdAct, weLow, wrCe, expDone;
      rdAct   = !mIsWr && mT >= 2 && mT <= RDN + 1;
      weLow   = mIsWr && mT >= 2 && mT <= WRN + 1;
      wrCe    = mIsWr && mT >= 2 && mT <= WRN + 2;
      expDone = (!mIsWr && mT == RDN + 2) || (mIsWr && mT == WRN + 2);
      ceRun   = sramCeN ? 0 : ceRun + 1;
      relRun  = !sramOeN ? 0 : relRun + 1;

      chk(reqReady == (mT >= mEnd), "R2", "reqReady", reqReady, mT >= mEnd);
      chk(sramCeN == !(rdAct || wrCe), mIsWr ? "R6" : "R3", "chip select", sramCeN, !(rdAct || wrCe));
      chk(sramOeN == !rdAct, "R3", "output enable", sramOeN, !rdAct);
      chk(sramWeN == !weLow, "R6", "write strobe", sramWeN, !weLow);
      chk(sramDqOe == wrCe, "R6", "bus drive", sramDqOe, wrCe);
      chk(sramBeN == mBe, "R9", "byte enables", sramBeN, mBe);
      chk(reqDone == expDone, "R11", "done pulse", reqDone, expDone);
      chk(!(!sramOeN && !sramWeN) && !(sramDqOe && !sramOeN), "R10", "oe/we/bus overlap",
          {sramOeN, sramWeN, sramDqOe}, 3'b110);
      if (rdAct || wrCe) chk(sramAddr == mAddr, mIsWr ? "R6" : "R3", "address", sramAddr, mAddr);
      if (wrCe) chk(sramDqOut == mData, "R6", "write data", sramDqOut, mData);
      if (expDone && !mIsWr) chk(rdData == mExpRd, "R4", "read data", rdData, mExpRd);
      if (mIsWr && mT == WRN + 2) begin
        chk(sramWeN && !sramCeN && sramDqOe, "R7", "hold cycle", {sramWeN, sramCeN, sramDqOe}, 3'b101);
        chk(ceRun >= WCYC, "R8", "write cycle length", ceRun, WCYC);
      end
      if (sramDqOe && !prevDqOe) chk(relRun >= RECN, "R5", "release gap", relRun, RECN);
      if (reqDone) doneSeen++;
      prevDqOe = sramDqOe;
    end
  end

  // ---------------- stimulus ----------------
  task automatic doReq(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit keep);
    reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    if (!keep) begin
      reqValid = 1'b0;
      // R2: fields scrambled while busy must be ignored
      reqWrite = ~wr; reqAddr = ~a; reqWdata = ~d; reqMask = ~m;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 16'h0000;
      shadow[i] = 16'h0000;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doReq(1, 18'h00010, 16'hA5C3, 2'b11, 0);
    doReq(0, 18'h00010, 16'h0000, 2'b11, 0);
    doReq(1, 18'h00010, 16'h1234, 2'b01, 0);
    doReq(0, 18'h00010, 16'h0000, 2'b11, 0);
    doReq(1, 18'h00010, 16'h5600, 2'b10, 0);
    doReq(0, 18'h00010, 16'h0000, 2'b01, 0);
    doReq(0, 18'h00010, 16'h0000, 2'b10, 0);
    doReq(1, 18'h3FF21, 16'hBEEF, 2'b11, 1);
    doReq(0, 18'h3FF21, 16'h0000, 2'b11, 1);
    doReq(1, 18'h00022, 16'h7788, 2'b11, 1);
    doReq(1, 18'h00023, 16'h99AA, 2'b10, 1);
    doReq(0, 18'h00022, 16'hFFFF, 2'b10, 0);
    repeat (3) @(negedge clk);
    begin
      int unsigned seed = 32'h1234_5678;
      for (int n = 0; n < 60; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        doReq(seed[20], {10'h000, 4'h0, seed[27:24]}, seed[15:0],
              (seed[22:21] == 2'b00) ? 2'b11 : seed[22:21], seed[23]);
      end
    end
    reqValid = 1'b0;
    repeat (20) @(negedge clk);
    chk(doneSeen == accepted, "R11", "done count", doneSeen, accepted);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule